// File: doc/BRIEF.md
# I2C Command Pacing Sequencer

This block sits between a command source and a byte-level I2C master engine. It accepts one command request at a time and expands it into a series of bus operations (START, address byte, command byte, data bytes, STOP) for one fixed target device. While it does this it applies the target's timing rules:

- an idle gap after every STOP before the next packet may start;
- single-byte write packets whenever the bus runs above 100 kHz;
- a settle interval after a read-write command before any result read;
- a cap on how often reads may be issued.

All intervals are counted in core clock cycles. A request that would break a rule is not dropped. It waits with `req_ready` low until the rule allows it.

Requests carry a command byte, up to two data bytes, a read flag, a length flag and a read-write flag. The engine side uses a single operation port. The sequencer holds `m_valid` high with an opcode until the engine returns `m_done`. Read results come back as a one-cycle response pulse.

Top module: `i2c_pacer`

## Requirements
- R1: After reset `m_valid` and `rsp_valid` are low, and `req_ready` is high for a request with `req_read` low.
- R2: After the STOP of any packet completes (`m_done` on a STOP), no new packet START is issued for at least GAP_CYC cycles. A request already waiting is taken as soon as that gap ends.
- R3: Two-byte write with `fast_sel` high is sent as two packets, separated by the gap of R2. The engine opcodes are START=0, WRITE=1, READ=2, STOP=3. Packet one is START, WRITE {DEV_ADDR,0}, WRITE cmd, WRITE data[7:0], STOP. Packet two is START, WRITE {DEV_ADDR,0}, WRITE cmd+1, WRITE data[15:8], STOP.
- R4: Two-byte write with `fast_sel` low is sent as one packet: START, {DEV_ADDR,0}, cmd, data[7:0], data[15:8], STOP.
- R5: Single-byte write (`req_two` low) is one packet, START, {DEV_ADDR,0}, cmd, data[7:0], STOP, whatever the value of `fast_sel`.
- R6: A read is sent as START, WRITE {DEV_ADDR,0}, WRITE cmd, START (repeated), WRITE {DEV_ADDR,1}, then one READ (`req_two` low) or two READs. Every READ except the last has `m_nack` low. The last READ has `m_nack` high. A STOP follows. The response carries {second byte, first byte}, or {8'h00, byte} for one byte.
- R7: After the final STOP of a write with `req_rw` high, no read request is accepted for SETTLE_CYC cycles. For a split write, the final STOP is the one that ends its second packet.
- R8: A write with `req_rw` low starts no settle interval. A read that follows it waits only for the gap of R2.
- R9: No more than two read requests are accepted within any window of RATE_WIN_CYC cycles. A third read is held until the older of the two leaves the window.
- R10: Requests that may not yet start are held with `req_ready` low, not lost. Only one request is in progress at a time. `m_op`, `m_wdata` and `m_nack` stay stable while `m_valid` is high and `m_done` has not come.
- R11: `rsp_valid` is a single-cycle pulse in the cycle after the last READ of a request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_sel | input | 1 | High when SCL is above 100 kHz (split writes) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_read | input | 1 | 1 = result read, 0 = write |
| req_rw | input | 1 | Write is a read-write command (arms settle interval) |
| req_two | input | 1 | 1 = two data bytes, 0 = one |
| req_cmd | input | 8 | Command byte (register address in the target) |
| req_data | input | 16 | Write data, low byte sent first |
| rsp_valid | output | 1 | Read result pulse |
| rsp_data | output | 16 | Read result, first byte in the low half |
| m_valid | output | 1 | Operation presented to the engine |
| m_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| m_wdata | output | 8 | Byte for a WRITE operation |
| m_nack | output | 1 | NACK the byte of a READ operation |
| m_done | input | 1 | Engine finished the presented operation |
| m_rdata | input | 8 | Byte read, valid with m_done |

## Verification
The in-module assertions watch, every cycle, the properties that are local in time:
- operations are held stable until the engine finishes them;
- no request is accepted while one is in flight;
- no packet can start the cycle right after a STOP;
- no read can be taken right after a read-write command ends;
- the response stays a single pulse.

The exact byte order of each packet shape (incremental, split, single-byte, one- and two-byte read) comes only from the bench's scenarios. So do the incremented command byte of a split packet, the exact length of the gap, settle and rate windows, and the returned read data.

// File: rtl/i2c_pacer.sv
module i2c_pacer #(
  parameter logic [6:0] DEV_ADDR = 7'h55,
  parameter int GAP_CYC      = 8250,
  parameter int SETTLE_CYC   = 250_000_000,
  parameter int RATE_WIN_CYC = 62_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fast_sel,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic        req_rw,
  input  logic        req_two,
  input  logic [7:0]  req_cmd,
  input  logic [15:0] req_data,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        m_valid,
  output logic [1:0]  m_op,
  output logic [7:0]  m_wdata,
  output logic        m_nack,
  input  logic        m_done,
  input  logic [7:0]  m_rdata
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int RW = $clog2(RATE_WIN_CYC + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_t;

  st_t st;
  logic [2:0] step;
  logic rd, rw, two, split, last;
  logic [7:0] cmd, d0, d1, lo;
  logic [GW-1:0] gap;
  logic [SW-1:0] settle;
  logic [RW-1:0] rt0, rt1;

  wire read_ok = (settle == '0) && (rt0 == '0 || rt1 == '0);
  assign req_ready = (st == S_IDLE) && (gap == '0) && (!req_read || read_ok);
  wire take = req_valid && req_ready;
  assign m_valid = (st == S_RUN);
  wire done = m_valid && m_done;
  wire fin  = done && last;
  wire more = !rd && two && split;

  always_comb begin
    m_op = OP_STOP; m_wdata = 8'h00; m_nack = 1'b0; last = 1'b0;
    if (rd) begin
      case (step)
        3'd0: m_op = OP_START;
        3'd1: begin m_op = OP_WR; m_wdata = {DEV_ADDR, 1'b0}; end
        3'd2: begin m_op = OP_WR; m_wdata = cmd; end
        3'd3: m_op = OP_START;
        3'd4: begin m_op = OP_WR; m_wdata = {DEV_ADDR, 1'b1}; end
        3'd5: begin m_op = OP_RD; m_nack = !two; end
        3'd6: if (two) begin m_op = OP_RD; m_nack = 1'b1; end else last = 1'b1;
        default: last = 1'b1;
      endcase
    end else begin
      case (step)
        3'd0: m_op = OP_START;
        3'd1: begin m_op = OP_WR; m_wdata = {DEV_ADDR, 1'b0}; end
        3'd2: begin m_op = OP_WR; m_wdata = cmd; end
        3'd3: begin m_op = OP_WR; m_wdata = d0; end
        3'd4: if (two && !split) begin m_op = OP_WR; m_wdata = d1; end else last = 1'b1;
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0;
      rd <= 1'b0; rw <= 1'b0; two <= 1'b0; split <= 1'b0;
      cmd <= '0; d0 <= '0; d1 <= '0; lo <= '0;
      gap <= '0; settle <= '0; rt0 <= '0; rt1 <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      gap <= fin ? GW'(GAP_CYC) : (gap != '0 ? gap - 1'b1 : gap);
      settle <= (fin && !rd && rw && !more) ? SW'(SETTLE_CYC)
              : (settle != '0 ? settle - 1'b1 : settle);
      rt0 <= (take && req_read && rt0 == '0) ? RW'(RATE_WIN_CYC)
           : (rt0 != '0 ? rt0 - 1'b1 : rt0);
      rt1 <= (take && req_read && rt0 != '0) ? RW'(RATE_WIN_CYC)
           : (rt1 != '0 ? rt1 - 1'b1 : rt1);
      case (st)
        S_IDLE: if (take) begin
          rd <= req_read; rw <= req_rw; two <= req_two; split <= fast_sel;
          cmd <= req_cmd; d0 <= req_data[7:0]; d1 <= req_data[15:8];
          step <= '0; st <= S_RUN;
        end
        S_RUN: if (done) begin
          if (rd && step == 3'd5) begin
            lo <= m_rdata;
            if (!two) begin rsp_valid <= 1'b1; rsp_data <= {8'h00, m_rdata}; end
          end
          if (rd && step == 3'd6 && two) begin
            rsp_valid <= 1'b1; rsp_data <= {m_rdata, lo};
          end
          if (last) begin
            step <= '0;
            if (more) begin
              cmd <= cmd + 8'd1; d0 <= d1; two <= 1'b0; st <= S_WAIT;
            end else st <= S_IDLE;
          end else step <= step + 3'd1;
        end
        S_WAIT: if (gap == '0) st <= S_RUN;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_done |=> m_valid && $stable(m_op) && $stable(m_wdata) && $stable(m_nack));
  p_one_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !m_valid);
  p_gap_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !req_ready && !m_valid);
  p_settle_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !rd && rw && !more |=> !(req_ready && req_read));
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rate_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_read && rt0 != '0 |=> !read_ok);
endmodule

// File: tb/i2c_pacer_test.sv
module i2c_pacer_test;
  localparam int G = 20, S = 300, RW = 200, LAT = 2;
  logic clk = 0, rst_n = 0;
  logic fast_sel = 0, req_valid = 0, req_read = 0, req_rw = 0, req_two = 0;
  logic [7:0] req_cmd = 0; logic [15:0] req_data = 0;
  logic req_ready, rsp_valid, m_valid, m_nack;
  logic [15:0] rsp_data; logic [1:0] m_op; logic [7:0] m_wdata;
  logic m_done = 0; logic [7:0] m_rdata = 0;

  i2c_pacer #(.DEV_ADDR(7'h55), .GAP_CYC(G), .SETTLE_CYC(S), .RATE_WIN_CYC(RW)) uut (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_rw(req_rw), .req_two(req_two), .req_cmd(req_cmd), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .m_valid(m_valid), .m_op(m_op), .m_wdata(m_wdata),
    .m_nack(m_nack), .m_done(m_done), .m_rdata(m_rdata));

  always #4 clk = ~clk;

  int cyc = 0, total = 0, fails = 0, busy = 0, rb = 0, kexp = 0, last_stop = -1;
  int cur_op = 0;
  bit finished = 0;
  int e_op[$], e_d[$], e_n[$]; string e_tag[$];
  int rsp_q[$]; int rd_starts[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", tag, act, exp); end
  endtask

  task automatic push(input int op, input int d, input int n, input string tag);
    e_op.push_back(op); e_d.push_back(d); e_n.push_back(n); e_tag.push_back(tag);
  endtask

  task automatic send(input bit rd, input bit rw, input bit two, input bit fast,
                      input [7:0] cmd, input [15:0] dat, input int ex, input string tag);
    push(0, ex, rd, tag); push(1, 8'hAA, 0, tag); push(1, cmd, 0, tag);
    if (rd) begin
      push(0, -1, 0, tag); push(1, 8'hAB, 0, tag);
      if (two) begin
        push(2, 0, 0, tag); push(2, 0, 1, tag);
        rsp_q.push_back({8'(8'h30 + kexp + 1), 8'(8'h30 + kexp)}); kexp += 2;
      end else begin
        push(2, 0, 1, tag); rsp_q.push_back({8'h00, 8'(8'h30 + kexp)}); kexp += 1;
      end
      push(3, 0, 0, tag);
    end else begin
      push(1, dat[7:0], 0, tag);
      if (two && !fast) push(1, dat[15:8], 0, tag);
      push(3, 0, 0, tag);
      if (two && fast) begin
        push(0, G + 2, 0, tag); push(1, 8'hAA, 0, tag); push(1, 8'(cmd + 8'd1), 0, tag);
        push(1, dat[15:8], 0, tag); push(3, 0, 0, tag);
      end
    end
    req_valid = 1; req_read = rd; req_rw = rw; req_two = two; fast_sel = fast;
    req_cmd = cmd; req_data = dat;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0; fast_sel = ~fast;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (m_done) m_done = 0;
    if (busy > 0) begin
      busy--;
      if (busy == 0) begin
        m_done = 1;
        if (cur_op == 2) begin m_rdata = 8'(8'h30 + rb); rb++; end
        if (cur_op == 3) last_stop = cyc;
      end
    end else if (m_valid) begin
      busy = LAT; cur_op = m_op;
      if (e_op.size() == 0) chk(0, "R10 unexpected op", m_op, -1);
      else begin
        automatic int o = e_op.pop_front(), d = e_d.pop_front(), n = e_n.pop_front();
        automatic string t = e_tag.pop_front();
        chk(m_op == o, {t, " opcode"}, m_op, o);
        if (o == 1) chk(m_wdata == d, {t, " byte"}, m_wdata, d);
        if (o == 2) chk(m_nack == n, {t, " nack"}, m_nack, n);
        if (o == 0 && d != -1) begin
          if (last_stop >= 0) chk(cyc - last_stop >= G + 2, "R2 gap", cyc - last_stop, G + 2);
          if (d > 0 && last_stop >= 0) chk(cyc - last_stop == d, {t, " start spacing"}, cyc - last_stop, d);
          if (n == 1) begin
            rd_starts.push_back(cyc);
            if (rd_starts.size() >= 3)
              chk(cyc - rd_starts[rd_starts.size() - 3] >= RW + 1, "R9 rate",
                  cyc - rd_starts[rd_starts.size() - 3], RW + 1);
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (rsp_q.size() == 0) chk(0, "R11 spurious response", rsp_data, -1);
    else begin
      automatic int e = rsp_q.pop_front();
      chk(rsp_data == 16'(e), "R6 read data", rsp_data, e);
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(negedge clk) if (cyc > 20000 && !finished) begin
    finished = 1;
    chk(0, "watchdog", cyc, 20000);
    summary(); $finish;
  end

  task automatic drain;
    while (e_op.size() != 0 || m_valid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(m_valid == 0, "R1 m_valid", m_valid, 0);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    send(0, 0, 1, 0, 8'h10, 16'hBEEF, 0, "R4 incremental");
    send(0, 0, 1, 1, 8'h20, 16'h1234, G + 2, "R3 split");
    send(0, 0, 0, 1, 8'h30, 16'h0077, G + 2, "R5 single fast");
    send(0, 0, 0, 0, 8'h31, 16'h0066, G + 2, "R5 single slow");
    send(1, 0, 1, 0, 8'h08, 16'h0, G + 2, "R8 R6 read after plain write");
    send(0, 1, 0, 0, 8'h00, 16'h0001, G + 2, "R10 rw write");
    send(1, 0, 1, 0, 8'h02, 16'h0, S + 2, "R7 settle read");
    send(1, 0, 0, 0, 8'h0C, 16'h0, G + 2, "R6 one byte read");
    drain();
    repeat (RW + 10) @(negedge clk);
    rd_starts.delete();
    send(1, 0, 0, 0, 8'h04, 16'h0, 0, "R9 read a");
    send(1, 0, 0, 0, 8'h06, 16'h0, G + 2, "R9 read b");
    send(1, 0, 0, 0, 8'h08, 16'h0, 0, "R9 read c");
    drain();
    if (rd_starts.size() == 3)
      chk(rd_starts[2] - rd_starts[0] == RW + 1, "R9 held third read", rd_starts[2] - rd_starts[0], RW + 1);
    else chk(0, "R9 read count", rd_starts.size(), 3);
    repeat (RW + 10) @(negedge clk);
    send(0, 1, 1, 1, 8'h40, 16'hA55A, 0, "R3 R7 split rw write");
    send(1, 0, 1, 1, 8'h40, 16'h0, S + 2, "R7 settle after split");
    drain();
    chk(rsp_q.size() == 0, "R11 responses all seen", rsp_q.size(), 0);
    chk(e_op.size() == 0, "R10 all ops issued", e_op.size(), 0);
    finished = 1;
    summary(); $finish;
  end
endmodule